// File: doc/BRIEF.md
# Oscillator Band Search Controller

This block chooses one of 24 oscillator bands for a frequency synthesizer. Each band is picked so that the loop tuning voltage ends up inside a window with margin on both sides. A 3-bit converter code reports where the tuning voltage sits. The controller drives a band index and reads that code back after a programmable settling delay. It then either accepts the band or moves one band up or down and tries again.

In manual mode the band index simply follows a programmed value, and the block runs no search. In automatic mode, a start pulse begins a search. The programmed value is the first candidate. Two flags report the outcome: one shows that the search has ended, and the other shows that a band was accepted. The accepted band is also held on a separate status output.

Top module: `osc_pick_ctrl`

## Requirements
- R1: After reset, `search_end_o`=1, `search_ok_o`=0, `vco_idx_o`=0 and `chosen_idx_o`=0.
- R2: While no search runs and `auto_i`=0, the clock edge loads `init_idx_i` into both `vco_idx_o` and `chosen_idx_o`, and visible one cycle later. A start pulse with `auto_i`=0 starts nothing.
- R3: A start pulse with `auto_i`=1 and `init_idx_i` in 0..23 makes, one cycle later, `search_end_o`=0, `search_ok_o`=0 and `vco_idx_o`=`init_idx_i`. `search_end_o` stays 0 until the search ends.
- R4: Let N be the `settle_i` value latched at the start. The converter code is sampled only at the (N+1)-th rising edge after each new index appears. Codes at earlier edges are ignored.
- R5: A sampled code of 3'b010 or 3'b101 ends the search with `search_end_o`=1 and `search_ok_o`=1, and `chosen_idx_o` is set to the current index. `vco_idx_o` keeps that index.
- R6: A sampled code of 3'b000 moves the index down by one. Codes 3'b111, 3'b001 and 3'b110 move it up by one. Each move restarts the settle wait, and during a search the index changes by at most one per cycle.
- R7: A code of 3'b000 at index 0, or any upward code at index 23, ends the search with `search_end_o`=1 and `search_ok_o`=0. `chosen_idx_o` and `vco_idx_o` are left unchanged.
- R8: If 24 candidates have been sampled and none qualified, the search ends with `search_end_o`=1 and `search_ok_o`=0.
- R9: A start pulse with `auto_i`=1 and `init_idx_i` above 23 sets, one cycle later, `search_end_o`=1 and `search_ok_o`=0. `vco_idx_o` is left unchanged.
- R10: A start pulse with `auto_i`=1 during a search restarts the search from `init_idx_i`, with a fresh `settle_i`. If it lands on the same edge as a code sample, the restart wins.
- R11: Dropping `auto_i` while a search runs does not stop that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Search launch pulse |
| auto_i | input | 1 | 1 = automatic search, 0 = manual index |
| init_idx_i | input | 5 | Programmed index / first candidate |
| settle_i | input | 8 | Settling wait in clocks after each index change |
| adc_code_i | input | 3 | Tuning-voltage converter code |
| vco_idx_o | output | 5 | Band index driven to the oscillator bank |
| chosen_idx_o | output | 5 | Reported accepted (or manual) index |
| search_end_o | output | 1 | 0 while a search runs, 1 otherwise |
| search_ok_o | output | 1 | 1 when the last search accepted a band |

## Verification
The two functions that can share a cycle are a relaunch pulse and the code-sampling edge of a running search. The bench counts the settle cycles so that a second start pulse is raised for exactly the edge on which the first candidate would be accepted with a qualifying code. It then expects the search to still be running, on the new index, instead of the success flags. A second overlap is a drop of the mode bit while a search is under way. Here the search must still finish with its accepted band, and only after that does the index start to follow the programmed value.

// File: rtl/osc_pick_pkg.sv
package osc_pick_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } srch_state_e;

    localparam logic [2:0] CODE_WIN_LO = 3'b010;
    localparam logic [2:0] CODE_WIN_HI = 3'b101;
    localparam logic [2:0] CODE_BOTTOM = 3'b000;

endpackage

// File: rtl/osc_code_class.sv
module osc_code_class
    import osc_pick_pkg::*;
(
    input  logic [2:0] code_i,
    output logic       qual_o,
    output logic       step_down_o
);

    always_comb begin
        qual_o      = (code_i == CODE_WIN_LO) || (code_i == CODE_WIN_HI);
        step_down_o = (code_i == CODE_BOTTOM);
    end

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [SETTLE_W-1:0] load_val_i,
    output logic                done_o
);

    logic [SETTLE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/osc_search_fsm.sv
module osc_search_fsm
    import osc_pick_pkg::*;
#(
    parameter int NUM_VCO  = 24,
    parameter int IDX_W    = 5,
    parameter int SETTLE_W = 8,
    parameter int TRY_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                auto_i,
    input  logic [IDX_W-1:0]    init_idx_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                qual_i,
    input  logic                step_down_i,
    input  logic                settle_done_i,
    output logic                tmr_load_o,
    output logic [SETTLE_W-1:0] tmr_val_o,
    output logic [IDX_W-1:0]    vco_idx_o,
    output logic [IDX_W-1:0]    chosen_idx_o,
    output logic                search_end_o,
    output logic                search_ok_o
);

    localparam logic [IDX_W-1:0] IDX_MAX   = IDX_W'(NUM_VCO - 1);
    localparam logic [TRY_W-1:0] TRY_LIMIT = TRY_W'(NUM_VCO);

    typedef struct packed {
        srch_state_e         st;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    chosen;
        logic [TRY_W-1:0]    tries;
        logic [SETTLE_W-1:0] settle;
        logic                fin;
        logic                ok;
    } fsm_t;

    fsm_t s_d, s_q;
    logic launch;
    logic at_edge;
    logic give_up;

    always_comb begin
        s_d        = s_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = s_q.settle;
        launch     = start_i && auto_i;
        at_edge    = step_down_i ? (s_q.idx == '0) : (s_q.idx == IDX_MAX);
        give_up    = (s_q.tries == TRY_LIMIT) || at_edge;

        if (launch) begin
            if (init_idx_i > IDX_MAX) begin
                s_d.st  = ST_IDLE;
                s_d.fin = 1'b1;
                s_d.ok  = 1'b0;
            end else begin
                s_d.st     = ST_SEARCH;
                s_d.idx    = init_idx_i;
                s_d.tries  = TRY_W'(1);
                s_d.settle = settle_i;
                s_d.fin    = 1'b0;
                s_d.ok     = 1'b0;
                tmr_load_o = 1'b1;
                tmr_val_o  = settle_i;
            end
        end else if (s_q.st == ST_SEARCH) begin
            if (settle_done_i) begin
                if (qual_i) begin
                    s_d.st     = ST_IDLE;
                    s_d.fin    = 1'b1;
                    s_d.ok     = 1'b1;
                    s_d.chosen = s_q.idx;
                end else if (give_up) begin
                    s_d.st  = ST_IDLE;
                    s_d.fin = 1'b1;
                    s_d.ok  = 1'b0;
                end else begin
                    s_d.idx    = step_down_i ? (s_q.idx - 1'b1) : (s_q.idx + 1'b1);
                    s_d.tries  = s_q.tries + 1'b1;
                    tmr_load_o = 1'b1;
                end
            end
        end else if (!auto_i) begin
            s_d.idx    = init_idx_i;
            s_d.chosen = init_idx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.idx    <= '0;
            s_q.chosen <= '0;
            s_q.tries  <= '0;
            s_q.settle <= '0;
            s_q.fin    <= 1'b1;
            s_q.ok     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vco_idx_o    = s_q.idx;
    assign chosen_idx_o = s_q.chosen;
    assign search_end_o = s_q.fin;
    assign search_ok_o  = s_q.ok;

endmodule

// File: rtl/osc_pick_ctrl.sv
module osc_pick_ctrl #(
    parameter int NUM_VCO  = 24,
    parameter int IDX_W    = 5,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                auto_i,
    input  logic [IDX_W-1:0]    init_idx_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [2:0]          adc_code_i,
    output logic [IDX_W-1:0]    vco_idx_o,
    output logic [IDX_W-1:0]    chosen_idx_o,
    output logic                search_end_o,
    output logic                search_ok_o
);

    localparam int TRY_W = $clog2(NUM_VCO + 1);

    logic                qual;
    logic                step_down;
    logic                settle_done;
    logic                tmr_load;
    logic [SETTLE_W-1:0] tmr_val;

    osc_code_class u_class (
        .code_i      (adc_code_i),
        .qual_o      (qual),
        .step_down_o (step_down)
    );

    osc_settle_timer #(
        .SETTLE_W (SETTLE_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (settle_done)
    );

    osc_search_fsm #(
        .NUM_VCO  (NUM_VCO),
        .IDX_W    (IDX_W),
        .SETTLE_W (SETTLE_W),
        .TRY_W    (TRY_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .auto_i        (auto_i),
        .init_idx_i    (init_idx_i),
        .settle_i      (settle_i),
        .qual_i        (qual),
        .step_down_i   (step_down),
        .settle_done_i (settle_done),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .vco_idx_o     (vco_idx_o),
        .chosen_idx_o  (chosen_idx_o),
        .search_end_o  (search_end_o),
        .search_ok_o   (search_ok_o)
    );

endmodule

// File: rtl/osc_pick_chk.sv
module osc_pick_chk #(
    parameter int NUM_VCO = 24,
    parameter int IDX_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             auto_i,
    input logic [IDX_W-1:0] init_idx_i,
    input logic [IDX_W-1:0] vco_idx_o,
    input logic [IDX_W-1:0] chosen_idx_o,
    input logic             search_end_o,
    input logic             search_ok_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_VCO - 1);

    AST_OK_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        search_ok_o |-> search_end_o); // R5

    AST_IDX_LEGAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !search_end_o |-> (vco_idx_o <= TOP_IDX)); // R6

    AST_LAUNCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && auto_i && (init_idx_i <= TOP_IDX)) |=>
        (!search_end_o && !search_ok_o && (vco_idx_o == $past(init_idx_i)))); // R3

    AST_BAD_INIT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && auto_i && (init_idx_i > TOP_IDX)) |=>
        (search_end_o && !search_ok_o && $stable(vco_idx_o))); // R9

    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (search_end_o && !auto_i) |=>
        ((vco_idx_o == $past(init_idx_i)) && (chosen_idx_o == $past(init_idx_i)))); // R2

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!search_end_o && !(start_i && auto_i)) |=>
        ((vco_idx_o == $past(vco_idx_o)) ||
         (vco_idx_o == $past(vco_idx_o) + 1'b1) ||
         (vco_idx_o == $past(vco_idx_o) - 1'b1))); // R6

    AST_SUCCESS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(search_ok_o) |-> (chosen_idx_o == vco_idx_o)); // R5

    AST_FAIL_KEEPS_CHOSEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(search_end_o) && !search_ok_o) |-> $stable(chosen_idx_o)); // R7

endmodule

bind osc_pick_ctrl osc_pick_chk #(
    .NUM_VCO (NUM_VCO),
    .IDX_W   (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .auto_i       (auto_i),
    .init_idx_i   (init_idx_i),
    .vco_idx_o    (vco_idx_o),
    .chosen_idx_o (chosen_idx_o),
    .search_end_o (search_end_o),
    .search_ok_o  (search_ok_o)
);

// File: tb/osc_pick_ctrl_tb.sv
module osc_pick_ctrl_tb_top;

    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       auto_m = 1'b0;
    logic [4:0] init_idx = '0;
    logic [7:0] settle = '0;
    logic [2:0] adc;
    logic [4:0] vco_idx, chosen_idx;
    logic       s_end, s_ok;

    logic [2:0] code_map [32];
    logic       ovr_en = 1'b0;
    logic [2:0] ovr_code = 3'b000;

    int    n_checks = 0;
    int    n_errs   = 0;
    bit    finished = 1'b0;
    string cur_req  = "R1";

    always #(CLK_PER/2) clk = ~clk;

    assign adc = ovr_en ? ovr_code : code_map[vco_idx];

    osc_pick_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .auto_i       (auto_m),
        .init_idx_i   (init_idx),
        .settle_i     (settle),
        .adc_code_i   (adc),
        .vco_idx_o    (vco_idx),
        .chosen_idx_o (chosen_idx),
        .search_end_o (s_end),
        .search_ok_o  (s_ok)
    );

    // behavioural reference model
    int m_busy, m_idx, m_chosen, m_tries, m_settle, m_wait, m_end, m_ok;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_idx = 0; m_chosen = 0; m_tries = 0;
            m_settle = 0; m_wait = 0; m_end = 1; m_ok = 0;
        end else if (start && auto_m) begin
            if (init_idx > 23) begin
                m_busy = 0; m_end = 1; m_ok = 0;
            end else begin
                m_busy = 1; m_idx = init_idx; m_tries = 1;
                m_settle = settle; m_wait = settle; m_end = 0; m_ok = 0;
            end
        end else if (m_busy != 0) begin
            if (m_wait > 0) begin
                m_wait = m_wait - 1;
            end else begin
                automatic logic [2:0] c = ovr_en ? ovr_code : code_map[m_idx];
                automatic int up = (c != 3'b000) ? 1 : 0;
                if (c == 3'b010 || c == 3'b101) begin
                    m_busy = 0; m_end = 1; m_ok = 1; m_chosen = m_idx;
                end else if (m_tries >= 24 || (up == 0 && m_idx == 0) || (up == 1 && m_idx == 23)) begin
                    m_busy = 0; m_end = 1; m_ok = 0;
                end else begin
                    m_idx = (up == 1) ? m_idx + 1 : m_idx - 1;
                    m_tries = m_tries + 1;
                    m_wait = m_settle;
                end
            end
        end else if (!auto_m) begin
            m_idx = init_idx; m_chosen = init_idx;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_req, int'(vco_idx), m_idx, "model vco_idx");
            chk(cur_req, int'(chosen_idx), m_chosen, "model chosen");
            chk(cur_req, int'(s_end), m_end, "model end");
            chk(cur_req, int'(s_ok), m_ok, "model ok");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_map();
        for (int i = 0; i < 32; i++) code_map[i] = 3'b111;
    endtask

    task automatic pulse_start(input logic [4:0] idx, input logic [7:0] s);
        init_idx = idx;
        settle   = s;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 400; i++) begin
            if (s_end) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PER * 60000);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        clear_map();
        tick(3);
        // R1: reset values
        chk("R1", int'(s_end), 1, "end in reset");
        chk("R1", int'(s_ok), 0, "ok in reset");
        chk("R1", int'(vco_idx), 0, "idx in reset");
        chk("R1", int'(chosen_idx), 0, "chosen in reset");
        rst_n = 1'b1;
        tick(1);

        // R2: manual follow, start ignored
        cur_req = "R2";
        init_idx = 5'd9;
        tick(2);
        chk("R2", int'(vco_idx), 9, "manual idx");
        chk("R2", int'(chosen_idx), 9, "manual chosen");
        pulse_start(5'd9, 8'd3);
        chk("R2", int'(s_end), 1, "start ignored in manual");
        tick(1);

        // R3 R5 R6: upward steps through locked codes to a qualifying one
        auto_m = 1'b1;
        cur_req = "R5";
        clear_map();
        code_map[4] = 3'b001; code_map[5] = 3'b110; code_map[6] = 3'b010;
        pulse_start(5'd4, 8'd3);
        chk("R3", int'(s_end), 0, "end low after launch");
        chk("R3", int'(vco_idx), 4, "first candidate");
        wait_end();
        chk("R5", int'(s_ok), 1, "success flag");
        chk("R6", int'(chosen_idx), 6, "chosen after up steps");

        // R6: downward steps
        cur_req = "R6";
        clear_map();
        code_map[10] = 3'b000; code_map[9] = 3'b000; code_map[8] = 3'b101;
        pulse_start(5'd10, 8'd2);
        wait_end();
        chk("R6", int'(chosen_idx), 8, "chosen after down steps");

        // R7: falls off the bottom, then off the top
        cur_req = "R7";
        clear_map();
        code_map[1] = 3'b000; code_map[0] = 3'b000;
        pulse_start(5'd1, 8'd1);
        wait_end();
        chk("R7", int'(s_ok), 0, "bottom fail ok");
        chk("R7", int'(vco_idx), 0, "bottom fail idx");
        chk("R7", int'(chosen_idx), 8, "bottom fail chosen kept");
        clear_map();
        pulse_start(5'd22, 8'd1);
        wait_end();
        chk("R7", int'(s_ok), 0, "top fail ok");
        chk("R7", int'(vco_idx), 23, "top fail idx");

        // R8: bounce between two bands until the candidate limit
        cur_req = "R8";
        clear_map();
        code_map[5] = 3'b111; code_map[6] = 3'b000;
        pulse_start(5'd5, 8'd0);
        wait_end();
        chk("R8", int'(s_ok), 0, "limit fail ok");
        chk("R8", int'(vco_idx), 6, "limit fail idx");
        chk("R8", int'(chosen_idx), 8, "limit fail chosen");

        // R9: illegal first candidate
        cur_req = "R9";
        pulse_start(5'd27, 8'd1);
        chk("R9", int'(s_end), 1, "bad init end");
        chk("R9", int'(s_ok), 0, "bad init ok");
        chk("R9", int'(vco_idx), 6, "bad init idx kept");

        // R4: qualifying code shown only before the sample edge is ignored
        cur_req = "R4";
        clear_map();
        code_map[3] = 3'b111; code_map[4] = 3'b101;
        init_idx = 5'd3; settle = 8'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0; ovr_code = 3'b010; ovr_en = 1'b1;
        tick(6);
        ovr_en = 1'b0;
        wait_end();
        chk("R4", int'(chosen_idx), 4, "early code ignored");

        // R10: relaunch on the very edge the first candidate would qualify
        cur_req = "R10";
        clear_map();
        code_map[12] = 3'b010; code_map[15] = 3'b000; code_map[14] = 3'b010;
        pulse_start(5'd12, 8'd3);
        tick(3);
        pulse_start(5'd15, 8'd2);
        chk("R10", int'(s_end), 0, "restart beats sample");
        chk("R10", int'(vco_idx), 15, "restart index");
        wait_end();
        chk("R10", int'(chosen_idx), 14, "restart result");

        // R11: mode drop during a search
        cur_req = "R11";
        clear_map();
        code_map[22] = 3'b010;
        pulse_start(5'd20, 8'd4);
        auto_m = 1'b0;
        wait_end();
        chk("R11", int'(s_ok), 1, "search survives mode drop");
        chk("R11", int'(chosen_idx), 22, "chosen after mode drop");
        tick(1);
        chk("R2", int'(vco_idx), 20, "manual follow resumes");

        tick(2);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule